// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vector Encoder

This block watches 256 interrupt sources and picks one of them to present to a processor. Sources 0 to 7 are request flags that software sets and clears over a simple register bus. Sources 8 to 255 are level request lines from hardware. Each source holds its own 4-bit priority, written over the same bus.

On every cycle a registered tree finds the pending source with the highest priority. When several sources share that priority, the lowest source index wins. The index of the winner is encoded as a 9-bit vector. A single request line to the processor goes high when the winner's priority is strictly greater than the processor's current priority input. A hardware request reaches that line after a fixed three clock edges.

A configuration register selects how the vector is delivered. In hardware mode it is driven on output ports, both as the raw vector and as a byte offset into a vector table. In software mode those ports read zero, and software reads the offset from an acknowledge address. A second configuration bit sets the table entry size to 4 or 8 bytes.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, `irq` is 0, every priority reads 0, every software flag reads 0, and the configuration reads 0 (software mode, 4-byte entries).
- R2: A hardware request driven before clock edge k raises `irq` after edge k+2 and not after edge k+1. That is a latency of three edges.
- R3: Among pending sources, the source with the numerically highest priority wins.
- R4: Among pending sources that share the highest priority, the one with the lowest index wins, inside a group of 16 and across groups.
- R5: `irq` is 1 only when the winning priority is strictly greater than `cur_prio`. An equal priority does not raise it. A change of `cur_prio` takes effect on `irq` after one clock edge.
- R6: A pending source with priority 0 never raises `irq`.
- R7: A write to address 256+i (i in 0..7) controls software flag i, which is request source i. Data bit 1 sets the flag and data bit 0 clears it. Writing both bits leaves the flag set. Bit 0 of a read at 256+i returns the flag.
- R8: The configuration register is at address 264. Bit 0 = 1 selects hardware mode, in which `irq_vec` and `irq_ofs` carry the winner. Bit 0 = 0 selects software mode, in which both ports read 0 and a read of address 265 returns the offset.
- R9: The offset is the vector times 4 when configuration bit 1 is 0, and times 8 when it is 1. This holds both on `irq_ofs` and on the read at address 265.
- R10: The vector equals the winning source index. `hw_req[k]` is source k+8.
- R11: A write to address a (0..255) sets the priority of source a to `wr_data`. A read of address a returns that priority in bits 3:0 of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 248 | Level request lines, bit k is source k+8 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 10 | Register read address |
| rd_data | output | 12 | Register read data (combinational) |
| cur_prio | input | 4 | Processor current priority |
| irq | output | 1 | Interrupt request to the processor |
| irq_vec | output | 9 | Winning vector (hardware mode, else 0) |
| irq_ofs | output | 12 | Vector table byte offset (hardware mode, else 0) |

## Verification
The assertions check on every cycle that a raised `irq` carries a winning priority above the previous cycle's `cur_prio` and never priority 0. They also check that a maximal `cur_prio` blocks `irq`, that a raised `irq` always has a pending source three edges earlier, and that a driven vector lies inside the source range. Only the bench scenarios can show that the right source wins: the highest priority, ties resolved by lowest index within and across groups, and the exact three-edge latency. The same holds for the set-dominant behaviour of the software flags and for the offset scaling and mode switching seen through the ports and the acknowledge read.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NSRC = 256,
  parameter int NSW  = 8,
  parameter int PW   = 4,
  parameter int VW   = 9,
  parameter int GSZ  = 16,
  parameter int AW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-NSW-1:0]  hw_req,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [PW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [VW+2:0]        rd_data,
  input  logic [PW-1:0]        cur_prio,
  output logic                 irq,
  output logic [VW-1:0]        irq_vec,
  output logic [VW+2:0]        irq_ofs
);
  localparam int NG    = NSRC / GSZ;
  localparam int IW    = $clog2(NSRC);
  localparam int A_SW  = NSRC;
  localparam int A_CFG = NSRC + NSW;
  localparam int A_ACK = A_CFG + 1;

  logic [PW-1:0]   prio_q [NSRC];
  logic [NSW-1:0]  swf_q;
  logic            hwmode_q, ent8_q;
  logic [NSRC-1:0] pend_q;

  logic [PW-1:0]   gp_d [NG], gp_q [NG];
  logic [VW-1:0]   gi_d [NG], gi_q [NG];
  logic [NG-1:0]   gv_d, gv_q;

  logic [PW-1:0]   fp;
  logic [VW-1:0]   fi;
  logic            fv;

  logic            irq_q;
  logic [VW-1:0]   vec_q;
  logic [PW-1:0]   win_p_q;
  logic [VW+2:0]   ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NSRC; i++)
        if (wr_addr == AW'(i)) prio_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swf_q    <= '0;
      hwmode_q <= 1'b0;
      ent8_q   <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NSW; i++)
        if (wr_addr == AW'(A_SW + i)) begin
          if (wr_data[1])      swf_q[i] <= 1'b1;
          else if (wr_data[0]) swf_q[i] <= 1'b0;
        end
      if (wr_addr == AW'(A_CFG)) begin
        hwmode_q <= wr_data[0];
        ent8_q   <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= {hw_req, swf_q};
  end

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      gp_d[g] = '0;
      gi_d[g] = VW'(g * GSZ);
      gv_d[g] = 1'b0;
      for (int j = 0; j < GSZ; j++)
        if (pend_q[g*GSZ+j] && (!gv_d[g] || prio_q[g*GSZ+j] > gp_d[g])) begin
          gv_d[g] = 1'b1;
          gp_d[g] = prio_q[g*GSZ+j];
          gi_d[g] = VW'(g*GSZ + j);
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= '0;
      for (int g = 0; g < NG; g++) begin
        gp_q[g] <= '0;
        gi_q[g] <= '0;
      end
    end else begin
      gv_q <= gv_d;
      for (int g = 0; g < NG; g++) begin
        gp_q[g] <= gp_d[g];
        gi_q[g] <= gi_d[g];
      end
    end
  end

  always_comb begin
    fp = '0;
    fi = '0;
    fv = 1'b0;
    for (int g = 0; g < NG; g++)
      if (gv_q[g] && (!fv || gp_q[g] > fp)) begin
        fv = 1'b1;
        fp = gp_q[g];
        fi = gi_q[g];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      vec_q   <= '0;
      win_p_q <= '0;
    end else begin
      irq_q   <= fv && (fp > cur_prio);
      vec_q   <= fi;
      win_p_q <= fp;
    end
  end

  assign ofs     = ent8_q ? {vec_q, 3'b000} : {1'b0, vec_q, 2'b00};
  assign irq     = irq_q;
  assign irq_vec = hwmode_q ? vec_q : '0;
  assign irq_ofs = hwmode_q ? ofs : '0;

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NSRC))
      rd_data = (VW+3)'(prio_q[rd_addr[IW-1:0]]);
    for (int i = 0; i < NSW; i++)
      if (rd_addr == AW'(A_SW + i)) rd_data = (VW+3)'(swf_q[i]);
    if (rd_addr == AW'(A_CFG)) rd_data = {{(VW+1){1'b0}}, ent8_q, hwmode_q};
    if (rd_addr == AW'(A_ACK)) rd_data = ofs;
  end
endmodule

module irq_prio_arb_chk #(
  parameter int PW   = 4,
  parameter int VW   = 9,
  parameter int NSRC = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [PW-1:0] cur_prio,
  input logic [PW-1:0] win_p,
  input logic          any_src,
  input logic [VW-1:0] irq_vec,
  input logic          hwmode
);
  p_above_cur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> win_p > $past(cur_prio));

  p_ceiling_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_prio) == {PW{1'b1}}) |-> !irq);

  p_zero_prio_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> win_p != '0);

  p_source_before_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(any_src, 3));

  p_vec_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && hwmode) |-> (int'(irq_vec) < NSRC));
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.PW(PW), .VW(VW), .NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .cur_prio (cur_prio),
  .win_p    (win_p_q),
  .any_src  (|{hw_req, swf_q}),
  .irq_vec  (irq_vec),
  .hwmode   (hwmode_q)
);

// File: tb/irq_prio_arb_test.sv
`timescale 1ns/1ps
module irq_prio_arb_test;
  localparam int NSRC = 256, NSW = 8, PW = 4, VW = 9, AW = 10;
  localparam int A_SW = 256, A_CFG = 264, A_ACK = 265;

  logic clk = 0, rst_n = 0;
  logic [NSRC-NSW-1:0] hw_req = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [PW-1:0] wr_data = '0, cur_prio = '0;
  logic [VW+2:0] rd_data, irq_ofs;
  logic irq;
  logic [VW-1:0] irq_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cur_prio(cur_prio),
    .irq(irq), .irq_vec(irq_vec), .irq_ofs(irq_ofs)
  );

  // {src_a[9], prio_a[4], src_b[9], prio_b[4], cur[4], exp_irq[1], exp_vec[9]}
  localparam logic [39:0] TBL [9] = '{
    {9'd10,  4'd5,  9'd20,  4'd7,  4'd0,  1'b1, 9'd20},  // R3
    {9'd30,  4'd9,  9'd12,  4'd9,  4'd0,  1'b1, 9'd12},  // R4 across groups
    {9'd100, 4'd3,  9'd200, 4'd3,  4'd3,  1'b0, 9'd0},   // R5 equal blocks
    {9'd100, 4'd3,  9'd200, 4'd4,  4'd3,  1'b1, 9'd200}, // R5
    {9'd255, 4'd15, 9'd8,   4'd14, 4'd14, 1'b1, 9'd255}, // R3 R10
    {9'd40,  4'd0,  9'd41,  4'd0,  4'd0,  1'b0, 9'd0},   // R6
    {9'd40,  4'd0,  9'd50,  4'd1,  4'd0,  1'b1, 9'd50},  // R6
    {9'd31,  4'd6,  9'd16,  4'd6,  4'd5,  1'b1, 9'd16},  // R4 same group
    {9'd47,  4'd2,  9'd33,  4'd2,  4'd1,  1'b1, 9'd33}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = AW'(a); wr_data = PW'(d); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(100, v); chk("R1 prio", v, 0);
    rd(A_SW + 5, v); chk("R1 flag", v, 0);
    rd(A_CFG, v); chk("R1 cfg", v, 0);
    @(negedge clk);

    wr(A_CFG, 1); // hardware mode, 4-byte entries

    for (int e = 0; e < 9; e++) begin
      int sa, pa, sb, pb, ei, ev;
      sa = int'(TBL[e][39:31]); pa = int'(TBL[e][30:27]);
      sb = int'(TBL[e][26:18]); pb = int'(TBL[e][17:14]);
      ei = int'(TBL[e][9]);     ev = int'(TBL[e][8:0]);
      hw_req = '0;
      repeat (4) @(negedge clk);
      wr(sa, pa);
      wr(sb, pb);
      cur_prio = TBL[e][13:10];
      hw_req[sa - NSW] = 1'b1;
      hw_req[sb - NSW] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("R2 row %0d early irq", e), int'(irq), 0);
      @(negedge clk);
      chk($sformatf("R3 R4 R5 R6 row %0d irq", e), int'(irq), ei);
      if (ei == 1) begin
        chk($sformatf("R10 row %0d vec", e), int'(irq_vec), ev);
        chk($sformatf("R9 row %0d ofs", e), int'(irq_ofs), ev * 4);
      end
    end

    hw_req = '0;
    cur_prio = '0;
    repeat (4) @(negedge clk);

    // R7 software flags
    wr(A_SW + 3, 3);
    rd(A_SW + 3, v); chk("R7 set+clear keeps set", v, 1);
    @(negedge clk);
    wr(3, 8);
    repeat (3) @(negedge clk);
    chk("R7 flag irq", int'(irq), 1);
    chk("R7 flag vec", int'(irq_vec), 3);
    wr(A_SW + 3, 1);
    rd(A_SW + 3, v); chk("R7 clear", v, 0);
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 cleared irq", int'(irq), 0);
    wr(A_SW + 3, 2);
    rd(A_SW + 3, v); chk("R7 set", v, 1);
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 set irq", int'(irq), 1);

    // R5 current priority gating
    cur_prio = 4'd8;
    @(negedge clk);
    chk("R5 equal cur drops irq", int'(irq), 0);
    cur_prio = 4'd7;
    @(negedge clk);
    chk("R5 lower cur raises irq", int'(irq), 1);

    // R9 and R8 modes
    wr(A_CFG, 3);
    chk("R9 ofs x8", int'(irq_ofs), 24);
    chk("R8 hw vec", int'(irq_vec), 3);
    wr(A_CFG, 0);
    chk("R8 sw vec zero", int'(irq_vec), 0);
    chk("R8 sw ofs zero", int'(irq_ofs), 0);
    chk("R8 irq kept", int'(irq), 1);
    rd(A_ACK, v); chk("R8 ack x4", v, 12);
    @(negedge clk);
    wr(A_CFG, 2);
    rd(A_ACK, v); chk("R9 ack x8", v, 24);
    chk("R8 sw vec still zero", int'(irq_vec), 0);

    // R11 priority readback
    rd(3, v); chk("R11 prio 3", v, 8);
    rd(255, v); chk("R11 prio 255", v, 15);
    rd(A_CFG, v); chk("R11 cfg", v, 2);
    @(negedge clk);

    finish_run();
  end
endmodule